// File: doc/BRIEF.md
# Masked-direction GPIO register bank

This block is a small bank of 16-bit registers on a simple memory-mapped write/read port, with sixteen general-purpose pins attached. Besides the pin direction and pin level registers it keeps a mode word, two configuration words, a power word, a constant status word, and three interrupt words: trigger, mask and status. The interrupt words are plain storage. Nothing in the block raises an interrupt from them.

A direction bit of 1 makes that pin an output. Each pin output is the stored level ANDed with its direction bit. The output is registered, so it follows the level and direction registers one cycle later. An update strobe pulses for one cycle on every pin whose output changed, and the logic that drives the pins acts only on those strobes. External inputs load individual bits of the level register through a per-bit strobe. A bus write to the level register is masked by the direction register, so it can only set bits of pins configured as outputs.

Top module: `gpio_regbank`

## Requirements
- R1: Decode looks only at address bits 5:0, and higher address bits alias. The offsets are: 0x00 mode, 0x04 config A, 0x08 status, 0x0C power, 0x10 config B, 0x14 irq trigger, 0x18 irq mask, 0x1C irq status, 0x20 direction, 0x24 level-write, 0x28 level-read. Any other offset reads 0 and ignores writes.
- R2: A write stores only wdata[15:0]. Bits above 15 of the bus are dropped.
- R3: The status register (0x08) always reads 0x0002, and writes to it have no effect.
- R4: A power write with wdata bit 7 = 1 stores wdata[15:0] | 0x8040. With bit 7 = 0 it stores wdata[15:0] unchanged.
- R5: gpio_out equals (level & direction) as it stood one clock earlier.
- R6: gpio_upd is high for exactly one cycle on each bit where gpio_out differs from its previous value, and is 0 on all other bits.
- R7: A write to offset 0x24 or 0x28 stores wdata[15:0] & direction into the level register. Both offsets read back the level register.
- R8: On a cycle with no level write, each level bit whose in_stb bit is 1 takes the matching in_val bit, and the other bits hold. A bus level write in the same cycle overrides in_stb on every bit.
- R9: After reset every stored register is 0, gpio_out and gpio_upd are 0, and status reads 0x0002.
- R10: Mode, config A, config B, irq trigger, irq mask, irq status and direction read back the last value written, with no side effect on other registers.
- R11: Writing the direction register never changes the level register. Clearing a direction bit drops that output, and setting it again brings back the stored level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Byte address; bits 5:0 decoded |
| wdata | input | BUS_W | Write data; low 16 bits used |
| we | input | 1 | Write strobe, one write per cycle |
| rdata | output | 16 | Read data for addr, combinational |
| in_stb | input | 16 | Per-bit load enable from external inputs |
| in_val | input | 16 | Per-bit level from external inputs |
| gpio_out | output | 16 | Registered masked pin outputs |
| gpio_upd | output | 16 | One-cycle strobe per changed output bit |

## Verification
The bench writes the level register with the direction partly cleared. A design that skipped the mask would read back the full write and drive pins configured as inputs. It turns a direction bit off and then on again. A design that cleared the level on a direction write would not bring the output back, and one that compared against the wrong previous value would pulse gpio_upd twice or not at all. It writes the power register with bit 7 set and clear, writes the status and an unknown offset, uses an aliased address above bit 5, and collides an input strobe with a bus level write. A wrong priority in that collision leaves the input value in the level register.

// File: rtl/gpio_regbank.sv
module gpio_regbank #(
  parameter int ADDR_W = 8,
  parameter int BUS_W = 32,
  parameter logic [15:0] STATUS_VAL = 16'h0002
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BUS_W-1:0]  wdata,
  input  logic              we,
  output logic [15:0]       rdata,
  input  logic [15:0]       in_stb,
  input  logic [15:0]       in_val,
  output logic [15:0]       gpio_out,
  output logic [15:0]       gpio_upd
);
  localparam int DW = 16;
  localparam int OW = 6;
  localparam logic [OW-1:0] A_MODE = 6'h00, A_CFGA = 6'h04, A_STAT = 6'h08,
                            A_PWR = 6'h0C, A_CFGB = 6'h10, A_TRIG = 6'h14,
                            A_MSK = 6'h18, A_IST = 6'h1C, A_DIR = 6'h20,
                            A_LVW = 6'h24, A_LVR = 6'h28;
  localparam logic [DW-1:0] PWR_FORCE = 16'h8040;

  logic [DW-1:0] mode_q, cfga_q, pwr_q, cfgb_q, trig_q, msk_q, ist_q;
  logic [DW-1:0] dir_q, lvl_q, out_q, upd_q;

  wire [OW-1:0] off = addr[OW-1:0];
  wire [DW-1:0] wd = wdata[DW-1:0];
  wire wr_lvl = we && (off == A_LVW || off == A_LVR);
  wire [DW-1:0] masked = lvl_q & dir_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0; cfga_q <= '0; pwr_q <= '0; cfgb_q <= '0;
      trig_q <= '0; msk_q <= '0; ist_q <= '0; dir_q <= '0;
    end else if (we) begin
      case (off)
        A_MODE: mode_q <= wd;
        A_CFGA: cfga_q <= wd;
        A_PWR:  pwr_q  <= wd[7] ? (wd | PWR_FORCE) : wd;
        A_CFGB: cfgb_q <= wd;
        A_TRIG: trig_q <= wd;
        A_MSK:  msk_q  <= wd;
        A_IST:  ist_q  <= wd;
        A_DIR:  dir_q  <= wd;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lvl_q <= '0;
    else if (wr_lvl) lvl_q <= wd & dir_q;
    else             lvl_q <= (lvl_q & ~in_stb) | (in_val & in_stb);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
      upd_q <= '0;
    end else begin
      out_q <= masked;
      upd_q <= masked ^ out_q;
    end
  end

  always_comb begin
    case (off)
      A_MODE: rdata = mode_q;
      A_CFGA: rdata = cfga_q;
      A_STAT: rdata = STATUS_VAL;
      A_PWR:  rdata = pwr_q;
      A_CFGB: rdata = cfgb_q;
      A_TRIG: rdata = trig_q;
      A_MSK:  rdata = msk_q;
      A_IST:  rdata = ist_q;
      A_DIR:  rdata = dir_q;
      A_LVW, A_LVR: rdata = lvl_q;
      default: rdata = '0;
    endcase
  end

  assign gpio_out = out_q;
  assign gpio_upd = upd_q;
endmodule

module gpio_regbank_chk #(
  parameter int ADDR_W = 8,
  parameter int BUS_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic [BUS_W-1:0]  wdata,
  input logic              we,
  input logic [15:0]       rdata,
  input logic [15:0]       gpio_out,
  input logic [15:0]       gpio_upd,
  input logic [15:0]       lvl_q,
  input logic [15:0]       dir_q,
  input logic [15:0]       pwr_q
);
  wire [5:0] off = addr[5:0];
  wire known = (off[1:0] == 2'b00) && (off <= 6'h28);

  p_unknown_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !known |-> rdata == 16'h0);
  p_status_const_r3: assert property (@(posedge clk) disable iff (!rst_n)
    off == 6'h08 |-> rdata == 16'h0002);
  p_power_force_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (we && off == 6'h0C && wdata[7]) |=> (pwr_q[15] && pwr_q[6] && pwr_q[7]));
  p_out_follows_r5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> gpio_out == ($past(lvl_q) & $past(dir_q)));
  p_upd_change_r6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> gpio_upd == (gpio_out ^ $past(gpio_out)));
  p_level_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (we && (off == 6'h24 || off == 6'h28)) |=> lvl_q == ($past(wdata[15:0]) & $past(dir_q)));
  p_dir_keeps_level_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (we && off == 6'h20) |=> $stable(lvl_q) || 1'b1 == 1'b1 && lvl_q == $past(lvl_q) || 1'b0);
endmodule

bind gpio_regbank gpio_regbank_chk #(.ADDR_W(ADDR_W), .BUS_W(BUS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .we(we), .rdata(rdata),
  .gpio_out(gpio_out), .gpio_upd(gpio_upd), .lvl_q(lvl_q), .dir_q(dir_q), .pwr_q(pwr_q)
);

// File: tb/sim_gpio_regbank.sv
`timescale 1ns/1ps
module sim_gpio_regbank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        we = 1'b0;
  logic [15:0] in_stb = '0, in_val = '0;
  logic [15:0] rdata, gpio_out, gpio_upd;

  int checks = 0, bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  gpio_regbank u0 (.clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .we(we),
    .rdata(rdata), .in_stb(in_stb), .in_val(in_val), .gpio_out(gpio_out), .gpio_upd(gpio_upd));

  logic [15:0] r[0:15];
  logic [15:0] m_out = '0, m_upd = '0;
  initial for (int i = 0; i < 16; i++) r[i] = '0;

  function automatic logic [15:0] m_rd(input logic [7:0] a);
    int k = int'(a[5:2]);
    if (a[1:0] != 2'b00 || k > 10) return 16'h0;
    if (k == 2) return 16'h0002;
    if (k == 10) return r[9];
    return r[k];
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) r[i] = '0;
      m_out = '0; m_upd = '0;
    end else begin
      logic [15:0] nxt;
      int k;
      nxt = r[9] & r[8];
      m_upd = nxt ^ m_out;
      m_out = nxt;
      k = int'(addr[5:2]);
      if (we && addr[1:0] == 2'b00 && (k == 9 || k == 10))
        r[9] = wdata[15:0] & r[8];
      else begin
        for (int b = 0; b < 16; b++) if (in_stb[b]) r[9][b] = in_val[b];
        if (we && addr[1:0] == 2'b00 && k <= 8 && k != 2)
          r[k] = (k == 3 && wdata[7]) ? (wdata[15:0] | 16'h8040) : wdata[15:0];
      end
    end
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    #2;
    if (!done) begin
      chk("R1 rdata vs model", rdata, m_rd(addr));
      chk("R5 gpio_out vs model", gpio_out, m_out);
      chk("R6 gpio_upd vs model", gpio_upd, m_upd);
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [15:0] exp, input string tag);
    @(negedge clk); addr = a; we = 1'b0;
    #1 chk(tag, rdata, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1 chk("R9 gpio_out in reset", gpio_out, 16'h0);
    rst_n = 1'b1;
    idle(1);
    rd(8'h00, 16'h0, "R9 mode after reset");
    rd(8'h20, 16'h0, "R9 direction after reset");
    rd(8'h08, 16'h0002, "R9 R3 status after reset");
    wr(8'h00, 32'hABCD_1234); rd(8'h00, 16'h1234, "R2 R10 mode truncated");
    wr(8'h04, 32'h0000_5A5A); rd(8'h04, 16'h5A5A, "R10 config A");
    wr(8'h10, 32'hFFFF_0F0F); rd(8'h10, 16'h0F0F, "R2 R10 config B");
    wr(8'h14, 32'h0000_1111); wr(8'h18, 32'h0000_2222); wr(8'h1C, 32'h0000_4444);
    rd(8'h14, 16'h1111, "R10 irq trigger");
    rd(8'h18, 16'h2222, "R10 irq mask");
    rd(8'h1C, 16'h4444, "R10 irq status");
    wr(8'h08, 32'h0000_FFFF); rd(8'h08, 16'h0002, "R3 status write ignored");
    wr(8'h2C, 32'h0000_FFFF); rd(8'h2C, 16'h0, "R1 unknown offset");
    rd(8'h02, 16'h0, "R1 unaligned offset");
    wr(8'h0C, 32'h0000_0081); rd(8'h0C, 16'h80C1, "R4 power bit7 set");
    wr(8'h0C, 32'h0000_0101); rd(8'h0C, 16'h0101, "R4 power bit7 clear");
    wr(8'h60, 32'h0000_00FF); rd(8'h20, 16'h00FF, "R1 aliased direction write");
    wr(8'h24, 32'h0000_FFFF); rd(8'h24, 16'h00FF, "R7 level write masked");
    rd(8'h28, 16'h00FF, "R7 level read alias");
    idle(1);
    chk("R5 output after level write", gpio_out, 16'h00FF);
    chk("R6 no repeated pulse", gpio_upd, 16'h0);
    wr(8'h28, 32'h0000_0F0F); rd(8'h24, 16'h000F, "R7 write via 0x28");
    wr(8'h20, 32'h0000_0000); rd(8'h24, 16'h000F, "R11 direction clear keeps level");
    idle(2); chk("R11 outputs dropped", gpio_out, 16'h0);
    wr(8'h20, 32'h0000_00FF); idle(2); chk("R11 outputs restored", gpio_out, 16'h000F);
    @(negedge clk); in_stb = 16'hF0F0; in_val = 16'hFFFF;
    @(negedge clk); in_stb = '0;
    rd(8'h24, 16'hF0FF, "R8 input strobe loads level");
    idle(2); chk("R8 R5 masked output of input", gpio_out, 16'h00FF);
    @(negedge clk); in_stb = 16'h0003; in_val = 16'h0000;
    @(negedge clk); in_stb = '0;
    rd(8'h24, 16'hF0FC, "R8 input strobe clears bits");
    @(negedge clk); addr = 8'h24; wdata = 32'h0000_0055; we = 1'b1;
    in_stb = 16'hFFFF; in_val = 16'hFFFF;
    @(negedge clk); we = 1'b0; in_stb = '0;
    rd(8'h24, 16'h0055, "R8 bus write overrides strobe");
    idle(4);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      checks++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end
endmodule